// File: doc/BRIEF.md
# Shared-Bus Four-Operation Arithmetic/Logic Datapath

This block is an 8-bit datapath with a small arithmetic/logic unit and four registers. An 8-bit switch word drives a shared bus. Three load strobes copy the bus value into operand register A, operand register B or opcode register I. A gate strobe runs the unit on the current A, B and I and writes the result into result register C. The outputs show all four registers and the current bus value.

The unit is built as a ripple chain of one-bit slices. It adds, ANDs, ORs, or inverts B. There is no subtract operation. To subtract, load B with the two's complement of the subtrahend and add. Software forms a two's complement with two passes: it inverts the value with the NOT operation, then adds one.

Strobes are plain control pins sampled on the rising clock edge. The block has no handshake. Each strobe acts in the cycle it is high.

Top module: `bus_alu_dp`

## Requirements
- R1: A synchronous active-high reset clears A, B, I and C to 0x00 on the next rising edge.
- R2: With only `ld_a` high, A takes `sw_in` at the rising edge. B, I and C keep their values.
- R3: With only `ld_b` high, B takes `sw_in` at the rising edge. A, I and C keep their values.
- R4: With only `ld_i` high, I takes `sw_in` at the rising edge. A, B and C keep their values.
- R5: A gate with I[1:0] = 2'b00 stores (A + B) mod 256 into C. The carry out of bit 7 is dropped, so 0x07+0x06 gives 0x0D, 0x07+0xFA gives 0x01 and 0xFF+0x01 gives 0x00.
- R6: A gate with I[1:0] = 2'b01 stores the bitwise AND of A and B into C.
- R7: A gate with I[1:0] = 2'b10 stores the bitwise OR of A and B into C.
- R8: A gate with I[1:0] = 2'b11 stores the bitwise inverse of B into C. The value of A has no effect on C.
- R9: Only I[1:0] selects the operation. Bits I[7:2] are ignored, so 0x06 acts as OR and 0xFD acts as AND.
- R10: When several strobes are high together, only the highest one acts, in the order gate, `ld_i`, `ld_b`, `ld_a`. C changes only on a gate.
- R11: `bus_out` equals `sw_in` while any load strobe is high. Otherwise it equals C.
- R12: Gating NOT on B = N, loading that result into A, loading B = 0x01 and then gating ADD leaves the two's complement of N in C. For N = 0x06 the result is 0xFA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 8 | Switch word driven onto the bus during loads |
| ld_a | input | 1 | Capture the bus into operand A |
| ld_b | input | 1 | Capture the bus into operand B |
| ld_i | input | 1 | Capture the bus into the opcode register |
| gate | input | 1 | Evaluate the unit and store the result in C |
| reg_a | output | 8 | Operand A contents |
| reg_b | output | 8 | Operand B contents |
| reg_i | output | 8 | Opcode register contents |
| reg_c | output | 8 | Result register contents |
| bus_out | output | 8 | Current shared bus value |

## Verification
The tests for addition use three operand pairs:
- 0x07 + 0x06 has no carry.
- 0x07 + 0xFA, where 0xFA is the negated subtrahend, carries out and then wraps.
- 0xFF + 0x01 carries through every slice and leaves zero.

Together these separate a correct ripple from one that drops the carry in or keeps the ninth bit.

The logic tests use the operands 0xCA and 0x5C. They differ in enough bit positions that AND, OR and NOT give three distinct results. The NOT test is gated again after A changes, to show A has no effect. The opcode test uses values with the upper bits set, and the strobe tests use overlapping strobes, to check decoding and priority.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  parameter int unsigned WORD_W = 8;
  parameter int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    OP_SUM  = 2'b00,
    OP_CONJ = 2'b01,
    OP_DISJ = 2'b10,
    OP_INVB = 2'b11
  } op_e;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic wr_i;
    logic wr_c;
  } grant_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import dpalu_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  input  op_e  op,
  output logic y_bit,
  output logic c_out
);
  logic half;
  logic sum_bit;

  always_comb begin
    half    = a_bit ^ b_bit;
    sum_bit = half ^ c_in;
    c_out   = (a_bit & b_bit) | (c_in & half);
    unique case (op)
      OP_SUM:  y_bit = sum_bit;
      OP_CONJ: y_bit = a_bit & b_bit;
      OP_DISJ: y_bit = a_bit | b_bit;
      OP_INVB: y_bit = ~b_bit;
      default: y_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ripple_unit.sv
module ripple_unit
  import dpalu_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  op_e          op,
  output logic [W-1:0] result
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_slice
    alu_slice u_slice (
      .a_bit (opnd_a[k]),
      .b_bit (opnd_b[k]),
      .c_in  (carry[k]),
      .op    (op),
      .y_bit (result[k]),
      .c_out (carry[k+1])
    );
  end

  logic [W-1:0] ref_sum;
  assign ref_sum = W'(opnd_a + opnd_b);

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUM) |-> (result == ref_sum)); // R5
  AST_AND_BITS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CONJ) |-> ((result | opnd_a) == opnd_a && (result | opnd_b) == opnd_b)); // R6
  AST_OR_BITS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DISJ) |-> ((result & opnd_a) == opnd_a && (result & opnd_b) == opnd_b)); // R7
  AST_NOT_B: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INVB) |-> ((result ^ opnd_b) == {W{1'b1}})); // R8
endmodule

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
  import dpalu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ld_a,
  input  logic   ld_b,
  input  logic   ld_i,
  input  logic   gate,
  output grant_t grant
);
  always_comb begin
    grant = '0;
    if (gate)      grant.wr_c = 1'b1;
    else if (ld_i) grant.wr_i = 1'b1;
    else if (ld_b) grant.wr_b = 1'b1;
    else if (ld_a) grant.wr_a = 1'b1;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant.wr_a, grant.wr_b, grant.wr_i, grant.wr_c})); // R10
  AST_GATE_WINS: assert property (@(posedge clk) disable iff (rst)
    gate |-> (grant.wr_c && !grant.wr_i && !grant.wr_b && !grant.wr_a)); // R10
endmodule

// File: rtl/bus_alu_dp.sv
module bus_alu_dp
  import dpalu_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw_in,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_i,
  input  logic              gate,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] reg_c,
  output logic [DATA_W-1:0] bus_out
);
  localparam int unsigned OPW = SEL_W;

  grant_t            grant;
  logic [DATA_W-1:0] bus_val;
  logic [DATA_W-1:0] alu_res;
  logic              any_load;
  op_e               cur_op;

  strobe_arbiter u_arb (
    .clk   (clk),
    .rst   (rst),
    .ld_a  (ld_a),
    .ld_b  (ld_b),
    .ld_i  (ld_i),
    .gate  (gate),
    .grant (grant)
  );

  assign any_load = ld_a | ld_b | ld_i;
  assign bus_val  = any_load ? sw_in : reg_c;
  assign bus_out  = bus_val;
  assign cur_op   = op_e'(reg_i[OPW-1:0]);

  ripple_unit #(.W(DATA_W)) u_unit (
    .clk    (clk),
    .rst    (rst),
    .opnd_a (reg_a),
    .opnd_b (reg_b),
    .op     (cur_op),
    .result (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
      reg_i <= '0;
      reg_c <= '0;
    end else begin
      if (grant.wr_a) reg_a <= bus_val;
      if (grant.wr_b) reg_b <= bus_val;
      if (grant.wr_i) reg_i <= bus_val;
      if (grant.wr_c) reg_c <= alu_res;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && reg_i == '0 && reg_c == '0)); // R1
  AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
    (ld_a && !ld_b && !ld_i && !gate) |=> (reg_a == $past(sw_in) && $stable(reg_b) && $stable(reg_i))); // R2
  AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
    (ld_b && !ld_i && !gate) |=> (reg_b == $past(sw_in) && $stable(reg_a))); // R3
  AST_LOAD_I: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !gate) |=> (reg_i == $past(sw_in) && $stable(reg_a) && $stable(reg_b))); // R4
  AST_C_ONLY_ON_GATE: assert property (@(posedge clk) disable iff (rst)
    !gate |=> $stable(reg_c)); // R10
  AST_GATE_STORE: assert property (@(posedge clk) disable iff (rst)
    gate |=> (reg_c == $past(alu_res) && $stable(reg_a) && $stable(reg_b) && $stable(reg_i))); // R5
endmodule

// File: tb/sim_bus_alu_dp.sv
module sim_bus_alu_dp;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] sw_in;
  logic       ld_a, ld_b, ld_i, gate;
  logic [7:0] reg_a, reg_b, reg_i, reg_c, bus_out;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bus_alu_dp u0 (
    .clk(clk), .rst(rst), .sw_in(sw_in), .ld_a(ld_a), .ld_b(ld_b),
    .ld_i(ld_i), .gate(gate), .reg_a(reg_a), .reg_b(reg_b),
    .reg_i(reg_i), .reg_c(reg_c), .bus_out(bus_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes at the falling edge; return at the next falling edge
  task automatic pulse(input logic [7:0] sw, input logic a, input logic b,
                       input logic i, input logic g);
    @(negedge clk);
    sw_in = sw; ld_a = a; ld_b = b; ld_i = i; gate = g;
    @(negedge clk);
    ld_a = 0; ld_b = 0; ld_i = 0; gate = 0; sw_in = 8'h00;
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] op);
    pulse(a, 1, 0, 0, 0);
    pulse(b, 0, 1, 0, 0);
    pulse(op, 0, 0, 1, 0);
    pulse(8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_reset;
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    check("R1 A", reg_a, 8'h00); check("R1 B", reg_b, 8'h00);
    check("R1 I", reg_i, 8'h00); check("R1 C", reg_c, 8'h00);
    run_op(8'h11, 8'h22, 8'h00);
    rst = 1; @(negedge clk); rst = 0;
    check("R1 A after use", reg_a, 8'h00); check("R1 C after use", reg_c, 8'h00);
  endtask

  task automatic t_loads;
    run_op(8'h01, 8'h02, 8'h00);            // C = 03
    pulse(8'h5A, 1, 0, 0, 0);
    check("R2 A", reg_a, 8'h5A); check("R2 B kept", reg_b, 8'h02);
    check("R2 C kept", reg_c, 8'h03);
    pulse(8'hA5, 0, 1, 0, 0);
    check("R3 B", reg_b, 8'hA5); check("R3 A kept", reg_a, 8'h5A);
    pulse(8'h02, 0, 0, 1, 0);
    check("R4 I", reg_i, 8'h02); check("R4 B kept", reg_b, 8'hA5);
    check("R4 C kept", reg_c, 8'h03);
  endtask

  task automatic t_add;
    run_op(8'h07, 8'h06, 8'h00); check("R5 7+6", reg_c, 8'h0D);
    run_op(8'h07, 8'hFA, 8'h00); check("R5 7-6", reg_c, 8'h01);
    run_op(8'hFF, 8'h01, 8'h00); check("R5 wrap", reg_c, 8'h00);
    run_op(8'h80, 8'h80, 8'h00); check("R5 msb carry", reg_c, 8'h00);
  endtask

  task automatic t_logic;
    run_op(8'hCA, 8'h5C, 8'h01); check("R6 AND", reg_c, 8'h48);
    run_op(8'hCA, 8'h5C, 8'h02); check("R7 OR", reg_c, 8'hDE);
    run_op(8'hAB, 8'h06, 8'h03); check("R8 NOT", reg_c, 8'hF9);
    pulse(8'h00, 1, 0, 0, 0);
    pulse(8'h00, 0, 0, 0, 1);
    check("R8 A ignored", reg_c, 8'hF9);
  endtask

  task automatic t_opcode_hi;
    run_op(8'hCA, 8'h5C, 8'h06); check("R9 0x06 as OR", reg_c, 8'hDE);
    run_op(8'hCA, 8'h5C, 8'hFD); check("R9 0xFD as AND", reg_c, 8'h48);
  endtask

  task automatic t_priority;
    run_op(8'h10, 8'h20, 8'h00);           // C = 30
    pulse(8'h33, 1, 1, 1, 1);
    check("R10 gate C", reg_c, 8'h30); check("R10 gate A kept", reg_a, 8'h10);
    check("R10 gate B kept", reg_b, 8'h20); check("R10 gate I kept", reg_i, 8'h00);
    pulse(8'h01, 1, 1, 1, 0);
    check("R10 I wins", reg_i, 8'h01); check("R10 I: B kept", reg_b, 8'h20);
    check("R10 I: A kept", reg_a, 8'h10); check("R10 I: C kept", reg_c, 8'h30);
    pulse(8'h44, 1, 1, 0, 0);
    check("R10 B wins", reg_b, 8'h44); check("R10 B: A kept", reg_a, 8'h10);
  endtask

  task automatic t_bus;
    run_op(8'h21, 8'h12, 8'h00);           // C = 33
    #1 check("R11 idle bus", bus_out, 8'h33);
    @(negedge clk);
    sw_in = 8'h9C; ld_b = 1;
    #1 check("R11 bus during load", bus_out, 8'h9C);
    @(negedge clk);
    ld_b = 0; ld_i = 1; gate = 1; sw_in = 8'h77;
    #1 check("R11 bus load+gate", bus_out, 8'h77);
    @(negedge clk);
    ld_i = 0; gate = 0; sw_in = 8'h00;
    #1 check("R11 idle again", bus_out, reg_c);
  endtask

  task automatic t_twos;
    run_op(8'h00, 8'h06, 8'h03);
    run_op(reg_c, 8'h01, 8'h00);
    check("R12 -6", reg_c, 8'hFA);
    run_op(8'h07, reg_c, 8'h00);
    check("R12 7+(-6)", reg_c, 8'h01);
  endtask

  initial begin
    rst = 1; sw_in = 0; ld_a = 0; ld_b = 0; ld_i = 0; gate = 0;
    t_reset;
    t_loads;
    t_add;
    t_logic;
    t_opcode_hi;
    t_priority;
    t_bus;
    t_twos;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule